// File: doc/BRIEF.md
# Hit-OR Time Stamper

The block time-stamps the leading edge of each column's hit-OR line. A hit-OR line is the OR of every pixel discriminator output in one column of a pixel matrix. Each line is sampled on both edges of a fast sampling clock, so the time bin is half a clock period. At 170 MHz that bin is about 2.94 ns. A time stamp is a free-running coarse count plus one bit that names the half period in which the line was first seen high. Each detected edge becomes one record, and the records queue in a small output FIFO with a valid/ready handshake.

Downstream logic pairs these stamps with pixel addresses from a much slower column-drain readout, which has 50 ns granularity. At high hit rates many columns can fire within a few clock cycles. For that reason the block keeps one pending stamp per column and empties the pending stamps into the FIFO at one per cycle, lowest column first. A record that cannot be stored is discarded, and a sticky flag records the loss.

Top module: `hitor_stamper`

## Requirements
- R1: While `rst_n` is low, and until the first record is produced after release, `rec_valid_o` and `ovf_o` are 0.
- R2: A record is `{column[COL_W-1:0], coarse[COARSE_W-1:0], half}` with `half` in bit 0, `coarse` directly above it and the column index in the top bits. COL_W is clog2(N_COL), with a minimum of 1.
- R3: If a line rises in the first half of a clock period (after a rising edge, before the next falling edge), `half` is 0. If it rises in the second half, `half` is 1. In both cases `coarse` is the number of rising edges of `clk` seen with `rst_n` high before the line rose.
- R4: The coarse count wraps silently modulo 2^COARSE_W, and a record taken across the wrap carries the wrapped value.
- R5: A line held high gives exactly one record. A new record needs the line to be low at both a falling-edge sample and the following rising-edge sample. A low that covers only a falling-edge sample gives no new record.
- R6: Columns that fire in the same half period enter the FIFO one per cycle in ascending column order, all with the same stamp.
- R7: While `rec_valid_o` is 1 and `rec_ready_i` is 0, `rec_valid_o` stays 1 and `rec_data_o` holds its value. Records leave in the order they were stored.
- R8: A record that reaches a full FIFO is discarded, and `ovf_o` becomes 1 and stays 1. Stored records are not affected.
- R9: Pulsing `clr_ovf_i` returns `ovf_o` to 0 on the next edge. If a record is discarded in that same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with `clk` |
| hit_i | input | N_COL | One hit-OR line per column |
| clr_ovf_i | input | 1 | Clears the overflow flag |
| rec_valid_o | output | 1 | A record is offered on `rec_data_o` |
| rec_ready_i | input | 1 | The consumer takes the offered record |
| rec_data_o | output | COL_W+COARSE_W+1 | Record: column, coarse count, half bit |
| ovf_o | output | 1 | Sticky flag: at least one record was discarded |

## Verification
The bench builds the block with six columns, a 6-bit coarse counter and a FIFO depth of 4. The short counter wraps every 64 cycles, so random stimulus crosses the wrap many times, and a directed case places one stamp on each side of it. Six columns are more than four FIFO slots, so firing every column at once while the consumer stalls must discard exactly two records. The same setup checks that the stored four come out in ascending column order. Random bursts over random column masks and both half periods are scored against stamps that the bench derives from its own count of clock edges.

// File: rtl/hs_pkg.sv
package hs_pkg;

  // Which half of the sampling period first saw a line high.
  typedef enum logic {
    HALF_EARLY = 1'b0,
    HALF_LATE  = 1'b1
  } half_e;

  // Depth of the reset release synchroniser.
  localparam int RST_SYNC_LEN = 2;

endpackage

// File: rtl/hs_edge_sampler.sv
module hs_edge_sampler
  import hs_pkg::*;
#(
  parameter int N_COL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_COL-1:0] hit_i,
  output logic [N_COL-1:0] det_o,
  output logic [N_COL-1:0] late_o
);

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    logic neg_q;
    logic neg_s1_q, neg_s2_q;
    logic pos_s1_q, pos_s2_q;
    logic prev_q;
    logic comb_w;

    // Falling-edge capture.
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) neg_q <= 1'b0;
      else        neg_q <= hit_i[c];
    end

    // Rising-edge capture and retiming of the falling sample.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        neg_s1_q <= 1'b0;
        neg_s2_q <= 1'b0;
        pos_s1_q <= 1'b0;
        pos_s2_q <= 1'b0;
        prev_q   <= 1'b0;
      end else begin
        neg_s1_q <= neg_q;
        neg_s2_q <= neg_s1_q;
        pos_s1_q <= hit_i[c];
        pos_s2_q <= pos_s1_q;
        prev_q   <= comb_w;
      end
    end

    // neg_s2_q is the earlier half, pos_s2_q the later half of one period.
    assign comb_w    = neg_s2_q | pos_s2_q;
    assign det_o[c]  = comb_w & ~prev_q;
    assign late_o[c] = neg_s2_q ? HALF_EARLY : HALF_LATE;
  end

endmodule

// File: rtl/hs_arbiter.sv
module hs_arbiter #(
  parameter int N_COL = 8,
  parameter int CRS_W = 12,
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_COL-1:0] det_i,
  input  logic [N_COL-1:0] late_i,
  input  logic [CRS_W-1:0] crs_i,
  input  logic             full_i,
  output logic [N_COL-1:0] gnt_o,
  output logic             push_o,
  output logic             drop_o,
  output logic [COL_W-1:0] pick_col_o,
  output logic [CRS_W-1:0] pick_crs_o,
  output logic             pick_late_o
);

  logic [N_COL-1:0] pend_q, pend_d;
  logic [N_COL-1:0] late_q;
  logic [CRS_W-1:0] crs_q [N_COL];
  logic [N_COL-1:0] load_w;
  logic [N_COL-1:0] collide_w;
  logic             found_w;

  // Lowest pending column wins.
  always_comb begin
    gnt_o       = '0;
    found_w     = 1'b0;
    pick_col_o  = '0;
    pick_crs_o  = '0;
    pick_late_o = 1'b0;
    for (int i = 0; i < N_COL; i++) begin
      if (pend_q[i] && !found_w) begin
        gnt_o[i]    = 1'b1;
        found_w     = 1'b1;
        pick_col_o  = COL_W'(i);
        pick_crs_o  = crs_q[i];
        pick_late_o = late_q[i];
      end
    end
  end

  // A slot accepts a new stamp when empty or when emptied this cycle.
  assign load_w    = det_i & (~pend_q | gnt_o);
  assign collide_w = det_i & pend_q & ~gnt_o;
  assign pend_d    = (pend_q & ~gnt_o) | det_i;

  assign push_o = found_w & ~full_i;
  assign drop_o = (found_w & full_i) | (|collide_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar c = 0; c < N_COL; c++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        crs_q[c]  <= '0;
        late_q[c] <= 1'b0;
      end else if (load_w[c]) begin
        crs_q[c]  <= crs_i;
        late_q[c] <= late_i[c];
      end
    end
  end

endmodule

// File: rtl/hs_fifo.sv
module hs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         rd_ready_i,
  output logic [W-1:0] rd_data_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_w, pop_w;

  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign valid_o   = (cnt_q != '0);
  assign rd_data_o = mem_q[rd_q];
  assign push_w    = wr_en_i & ~full_o;
  assign pop_w     = valid_o & rd_ready_i;

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push_w) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_w)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    cnt_d = cnt_q + CNT_W'(push_w) - CNT_W'(pop_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push_w && (wr_q == PTR_W'(e))) mem_q[e] <= wr_data_i;
    end
  end

endmodule

// File: rtl/hitor_stamper.sv
module hitor_stamper
  import hs_pkg::*;
#(
  parameter  int N_COL      = 8,
  parameter  int COARSE_W   = 12,
  parameter  int FIFO_DEPTH = 4,
  localparam int COL_W      = (N_COL > 1) ? $clog2(N_COL) : 1,
  localparam int REC_W      = COL_W + COARSE_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_COL-1:0] hit_i,
  input  logic             clr_ovf_i,
  output logic             rec_valid_o,
  input  logic             rec_ready_i,
  output logic [REC_W-1:0] rec_data_o,
  output logic             ovf_o
);

  logic [RST_SYNC_LEN-1:0] rs_q;
  logic                    irst_n;
  logic [COARSE_W-1:0]     cnt_q, cnt_d;
  logic                    ovf_q, ovf_d;
  logic [N_COL-1:0]        det_w, late_w, gnt_w;
  logic                    push_w, drop_w, full_w;
  logic [COL_W-1:0]        pick_col_w;
  logic [COARSE_W-1:0]     pick_crs_w;
  logic                    pick_late_w;

  // Reset asserts at once and releases on clk.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_SYNC_LEN-2:0], 1'b1};
  end
  assign irst_n = rs_q[RST_SYNC_LEN-1];

  // Free-running coarse count.
  assign cnt_d = cnt_q + 1'b1;
  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  hs_edge_sampler #(.N_COL(N_COL)) u_samp (
    .clk    (clk),
    .rst_n  (irst_n),
    .hit_i  (hit_i),
    .det_o  (det_w),
    .late_o (late_w)
  );

  hs_arbiter #(.N_COL(N_COL), .CRS_W(COARSE_W), .COL_W(COL_W)) u_arb (
    .clk         (clk),
    .rst_n       (irst_n),
    .det_i       (det_w),
    .late_i      (late_w),
    .crs_i       (cnt_q),
    .full_i      (full_w),
    .gnt_o       (gnt_w),
    .push_o      (push_w),
    .drop_o      (drop_w),
    .pick_col_o  (pick_col_w),
    .pick_crs_o  (pick_crs_w),
    .pick_late_o (pick_late_w)
  );

  hs_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (irst_n),
    .wr_en_i    (push_w),
    .wr_data_i  ({pick_col_w, pick_crs_w, pick_late_w}),
    .full_o     (full_w),
    .valid_o    (rec_valid_o),
    .rd_ready_i (rec_ready_i),
    .rd_data_o  (rec_data_o)
  );

  // Sticky loss flag; a discard in the clearing cycle keeps it set.
  always_comb begin
    ovf_d = ovf_q;
    if (clr_ovf_i) ovf_d = 1'b0;
    if (drop_w)    ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) ovf_q <= 1'b0;
    else         ovf_q <= ovf_d;
  end
  assign ovf_o = ovf_q;

endmodule

// File: rtl/hitor_stamper_chk.sv
module hitor_stamper_chk #(
  parameter int N_COL = 8,
  parameter int REC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_ovf_i,
  input logic             rec_valid_o,
  input logic             rec_ready_i,
  input logic [REC_W-1:0] rec_data_o,
  input logic             ovf_o,
  input logic [N_COL-1:0] det_w,
  input logic [N_COL-1:0] gnt_w,
  input logic             drop_w
);

  // R7: a stalled record is held unchanged
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_data_o)));

  // R8: the flag stays set without a clear
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_ovf_i) |=> ovf_o);

  // R8: a discarded record raises the flag
  p_drop_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w |=> ovf_o);

  // R9: a clear with no discard lowers the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf_i && !drop_w) |=> !ovf_o);

  // R6: at most one column is emptied per cycle
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_w));

  // R5: a column never detects in two consecutive cycles
  p_no_redetect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |det_w |=> ((det_w & $past(det_w)) == '0));

endmodule

bind hitor_stamper hitor_stamper_chk #(.N_COL(N_COL), .REC_W(REC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_ovf_i   (clr_ovf_i),
  .rec_valid_o (rec_valid_o),
  .rec_ready_i (rec_ready_i),
  .rec_data_o  (rec_data_o),
  .ovf_o       (ovf_o),
  .det_w       (det_w),
  .gnt_w       (gnt_w),
  .drop_w      (drop_w)
);

// File: tb/hitor_stamper_tb.sv
module hitor_stamper_tb;

  localparam int CLK_P = 10;
  localparam int NC    = 6;
  localparam int CW    = 6;
  localparam int DEP   = 4;
  localparam int COL_W = 3;
  localparam int REC_W = COL_W + CW + 1;
  localparam int WRAP  = 1 << CW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NC-1:0]    hit = '0;
  logic             clr = 1'b0;
  logic             rdy = 1'b0;
  logic             vld;
  logic [REC_W-1:0] dat;
  logic             ovf;

  int nt = 0;
  int nf = 0;
  int edges = 0;
  logic [REC_W-1:0] got[$];
  logic [REC_W-1:0] expq[$];

  hitor_stamper #(.N_COL(NC), .COARSE_W(CW), .FIFO_DEPTH(DEP)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_i       (hit),
    .clr_ovf_i   (clr),
    .rec_valid_o (vld),
    .rec_ready_i (rdy),
    .rec_data_o  (dat),
    .ovf_o       (ovf)
  );

  always #(CLK_P / 2) clk = ~clk;

  always @(posedge clk) if (rst_n) edges++;

  always @(negedge clk) if (rst_n && vld && rdy) got.push_back(dat);

  function automatic logic [REC_W-1:0] mk(int col, int crs, int late);
    return {COL_W'(col), CW'(crs), 1'(late)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nt++;
    if (!ok) begin
      nf++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Raise the lines in mask in the first (late=0) or second half of a period.
  task automatic drive(logic [NC-1:0] mask, int late, output int crs);
    @(posedge clk);
    #(late ? 7 : 2);
    crs = edges % WRAP;
    hit = hit | mask;
  endtask

  initial begin
    #(CLK_P * 150000);
    nf++;
    nt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    int c0, c1;
    void'($urandom(32'd4242));
    // R1 reset state
    cycles(3);
    chk(vld == 1'b0, "R1 valid in reset", 32'(vld), 0);
    chk(ovf == 1'b0, "R1 ovf in reset", 32'(ovf), 0);
    @(posedge clk); #3; rst_n = 1'b1;
    cycles(4);
    chk(vld == 1'b0, "R1 valid after release", 32'(vld), 0);
    chk(ovf == 1'b0, "R1 ovf after release", 32'(ovf), 0);
    rdy = 1'b1;

    // R2 / R3: early and late half
    got.delete();
    drive(6'b000010, 0, c0);
    cycles(4); hit = '0; cycles(8);
    chk(got.size() == 1, "R3 one record early", 32'(got.size()), 1);
    if (got.size() > 0) chk(got[0] == mk(1, c0, 0), "R2 R3 early record", 32'(got[0]), 32'(mk(1, c0, 0)));
    got.delete();
    drive(6'b001000, 1, c1);
    cycles(4); hit = '0; cycles(8);
    chk(got.size() == 1, "R3 one record late", 32'(got.size()), 1);
    if (got.size() > 0) chk(got[0] == mk(3, c1, 1), "R2 R3 late record", 32'(got[0]), 32'(mk(3, c1, 1)));

    // R5: held high, short low, full low
    got.delete();
    drive(6'b000001, 0, c0);
    cycles(30);
    chk(got.size() == 1, "R5 held line once", 32'(got.size()), 1);
    @(posedge clk); #3; hit[0] = 1'b0; #4; hit[0] = 1'b1;
    cycles(10);
    chk(got.size() == 1, "R5 half-period low ignored", 32'(got.size()), 1);
    hit[0] = 1'b0; cycles(3);
    drive(6'b000001, 1, c1);
    cycles(3); hit = '0; cycles(8);
    chk(got.size() == 2, "R5 rearm after full low", 32'(got.size()), 2);
    if (got.size() > 1) chk(got[1] == mk(0, c1, 1), "R5 rearm record", 32'(got[1]), 32'(mk(0, c1, 1)));

    // R6: same-period columns in ascending order
    got.delete();
    drive(6'b110100, 0, c0);
    cycles(4); hit = '0; cycles(12);
    chk(got.size() == 3, "R6 three records", 32'(got.size()), 3);
    if (got.size() == 3) begin
      chk(got[0] == mk(2, c0, 0), "R6 first col 2", 32'(got[0]), 32'(mk(2, c0, 0)));
      chk(got[1] == mk(4, c0, 0), "R6 second col 4", 32'(got[1]), 32'(mk(4, c0, 0)));
      chk(got[2] == mk(5, c0, 0), "R6 third col 5", 32'(got[2]), 32'(mk(5, c0, 0)));
    end

    // R4: stamps on both sides of the wrap
    got.delete();
    do begin @(posedge clk); #2; end while ((edges % WRAP) != WRAP - 1);
    hit[2] = 1'b1;
    @(posedge clk); #2; hit[3] = 1'b1;
    cycles(4); hit = '0; cycles(10);
    chk(got.size() == 2, "R4 two records", 32'(got.size()), 2);
    if (got.size() == 2) begin
      chk(got[0] == mk(2, WRAP - 1, 0), "R4 before wrap", 32'(got[0]), 32'(mk(2, WRAP - 1, 0)));
      chk(got[1] == mk(3, 0, 0), "R4 after wrap", 32'(got[1]), 32'(mk(3, 0, 0)));
    end

    // R7 / R8 / R9: stall, overflow, clear
    @(posedge clk); #1; rdy = 1'b0;
    got.delete();
    drive(6'b111111, 0, c0);
    cycles(4); hit = '0; cycles(15);
    chk(ovf == 1'b1, "R8 overflow set", 32'(ovf), 1);
    chk(vld == 1'b1, "R7 valid while stalled", 32'(vld), 1);
    chk(dat == mk(0, c0, 0), "R7 head record", 32'(dat), 32'(mk(0, c0, 0)));
    cycles(5);
    chk(dat == mk(0, c0, 0), "R7 head held", 32'(dat), 32'(mk(0, c0, 0)));
    rdy = 1'b1;
    cycles(10);
    chk(got.size() == DEP, "R8 only depth kept", 32'(got.size()), DEP);
    for (int i = 0; i < DEP; i++)
      if (i < got.size()) chk(got[i] == mk(i, c0, 0), "R8 R7 kept order", 32'(got[i]), 32'(mk(i, c0, 0)));
    chk(ovf == 1'b1, "R8 overflow sticky", 32'(ovf), 1);
    @(posedge clk); #1; clr = 1'b1;
    @(posedge clk); #1; clr = 1'b0;
    chk(ovf == 1'b0, "R9 overflow cleared", 32'(ovf), 0);

    // Random bursts (R3, R6)
    got.delete();
    expq.delete();
    for (int it = 0; it < 60; it++) begin
      logic [NC-1:0] m;
      int late, hold, crs;
      m    = NC'($urandom_range(1, (1 << NC) - 1));
      late = $urandom_range(0, 1);
      hold = $urandom_range(2, 6);
      drive(m, late, crs);
      for (int c = 0; c < NC; c++) if (m[c]) expq.push_back(mk(c, crs, late));
      cycles(hold);
      hit = '0;
      cycles(5 + $urandom_range(0, 3));
    end
    cycles(20);
    chk(got.size() == expq.size(), "R3 random record count", 32'(got.size()), 32'(expq.size()));
    foreach (got[k]) begin
      int idx;
      idx = -1;
      foreach (expq[j]) if (idx < 0 && expq[j] == got[k]) idx = j;
      chk(idx >= 0, "R3 random record expected", 32'(got[k]), 32'(got[k]));
      if (idx >= 0) expq.delete(idx);
    end
    chk(ovf == 1'b0, "R8 no loss when drained", 32'(ovf), 0);

    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

endmodule